// File: doc/BRIEF.md
# Per-Colour Black-Level Offset Corrector

This block sits in the digital path behind a three-colour linear image sensor and its converter. Every incoming sample carries a colour tag, a segment tag (shielded black reference pixel, active pixel or dummy pixel) and a line-start flag. The black pixels of each colour are averaged to estimate that colour's dark offset. The estimate is then subtracted from every active pixel of the same colour.

Three independent black-level registers are kept, one per colour, because each colour channel settles at a different dark level. Each register is rebuilt from its own colour's black run on every line. The colours may arrive one whole line at a time or interleaved pixel by pixel, and both arrangements work. Corrected samples leave one cycle after they enter, clamped at zero and tagged with their colour. Dummy samples and samples with no colour produce nothing.

Top module: `ob_offset_corr`

## Requirements
- R1: Colour code on `in_color`: 2'b01 red, 2'b10 green, 2'b11 blue. A sample with code 2'b00 produces no output and does not change any black level.
- R2: Segment code on `in_seg`: 2'b00 black reference, 2'b01 active. Codes 2'b10 and 2'b11 are dummy samples, which are dropped with no output.
- R3: An accepted active sample (`in_valid`, `in_seg`=2'b01, colour not 2'b00) appears one cycle later with `out_valid` high and the same colour on `out_color`. Its value is the sample minus that colour's current black level.
- R4: When the black level exceeds the active sample, `out_sample` is 0.
- R5: A colour's black level becomes floor(S/48), where S is the sum of the first 48 black samples of that colour since the last line start. It is committed on the 48th such sample and is used by active samples of that colour from the next cycle on. Before the commit, the earlier level stays in use.
- R6: Each colour's black level depends only on that colour's black samples, including when colours interleave pixel by pixel.
- R7: After reset, `out_valid` is low and every black level is 0.
- R8: Black samples of a colour beyond the 48th in a line are ignored.
- R9: A valid sample with `in_line_start` high restarts the black count and sum of every colour. A partial run of fewer than 48 samples is discarded, and the colour's black level is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input sample strobe |
| in_line_start | input | 1 | First sample of a line; restarts black runs |
| in_color | input | 2 | Colour tag |
| in_seg | input | 2 | Segment tag |
| in_sample | input | W | Digitised pixel value |
| out_valid | output | 1 | Corrected sample strobe |
| out_color | output | 2 | Colour of the corrected sample |
| out_sample | output | W | Offset-corrected, zero-clamped value |

## Verification
Every corrected sample is due exactly one clock edge after its input edge. A new black level is due at the edge that takes the 48th black sample, so an active sample driven in the very next cycle already sees it. The bench drives on falling edges and pushes the expected value and colour at drive time. A monitor compares each strobe at the following falling edge. After every dropped sample, an explicit check confirms that no strobe appeared at that point.

// File: rtl/ob_corr_pkg.sv
package ob_corr_pkg;

    typedef enum logic [1:0] {
        CLR_NONE = 2'b00,
        CLR_RED  = 2'b01,
        CLR_GRN  = 2'b10,
        CLR_BLU  = 2'b11
    } color_e;

    typedef enum logic [1:0] {
        SEG_BLACK  = 2'b00,
        SEG_ACTIVE = 2'b01,
        SEG_DUMMYA = 2'b10,
        SEG_DUMMYB = 2'b11
    } seg_e;

    localparam int NUM_COLORS = 3;

endpackage

// File: rtl/ob_black_lane.sv
module ob_black_lane #(
    parameter int W = 12,
    parameter int N = 48
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         take,
    input  logic         clr,
    input  logic [W-1:0] sample,
    output logic [W-1:0] black
);
    localparam int CLG    = $clog2(N);
    localparam int CNT_W  = $clog2(N + 1);
    localparam int SUM_W  = W + CLG;
    localparam int SHIFT  = SUM_W + CLG + 1;
    localparam int RECIP_W = SHIFT - CLG + 1;
    localparam int PROD_W = SUM_W + RECIP_W;
    localparam longint unsigned RECIP = ((64'd1 << SHIFT) + N - 1) / N;

    typedef struct packed {
        logic [SUM_W-1:0] acc;
        logic [CNT_W-1:0] cnt;
        logic [W-1:0]     black;
    } lane_t;

    lane_t st_d, st_q;
    logic [SUM_W-1:0]  sum_w;
    logic [PROD_W-1:0] prod_w;

    always_comb begin
        st_d   = st_q;
        sum_w  = '0;
        prod_w = '0;
        if (clr) begin
            st_d.acc = '0;
            st_d.cnt = '0;
        end
        if (take && (st_d.cnt < CNT_W'(N))) begin
            sum_w    = st_d.acc + SUM_W'(sample);
            st_d.acc = sum_w;
            st_d.cnt = st_d.cnt + 1'b1;
            if (st_d.cnt == CNT_W'(N)) begin
                prod_w     = PROD_W'(sum_w) * PROD_W'(RECIP);
                st_d.black = W'(prod_w >> SHIFT);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign black = st_q.black;

    // R8: the run counter never passes the black run length
    p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(N));

    // R5 / R6: the level moves only on this colour's own black sample
    p_black_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> $stable(st_q.black));

    // R9: a line start without a sample leaves an empty run
    p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !take) |=> (st_q.cnt == '0));

endmodule

// File: rtl/ob_clamp_sub.sv
module ob_clamp_sub #(
    parameter int W = 12
) (
    input  logic [W-1:0] minuend,
    input  logic [W-1:0] subtrahend,
    output logic [W-1:0] diff
);
    always_comb begin
        if (minuend >= subtrahend) diff = minuend - subtrahend;
        else                       diff = '0;
    end
endmodule

// File: rtl/ob_offset_corr.sv
module ob_offset_corr #(
    parameter int W = 12,
    parameter int N = 48
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic         in_line_start,
    input  logic [1:0]   in_color,
    input  logic [1:0]   in_seg,
    input  logic [W-1:0] in_sample,
    output logic         out_valid,
    output logic [1:0]   out_color,
    output logic [W-1:0] out_sample
);
    import ob_corr_pkg::*;

    typedef struct packed {
        logic         vld;
        logic [1:0]   color;
        logic [W-1:0] data;
    } out_t;

    logic [NUM_COLORS-1:0] take_ob;
    logic [W-1:0]          black_lvl [NUM_COLORS];
    logic                  line_clr;
    logic                  accept;
    logic [W-1:0]          sel_black;
    logic [W-1:0]          diff_w;
    out_t                  o_d, o_q;

    assign line_clr = in_valid && in_line_start;
    assign accept   = in_valid && (in_seg == SEG_ACTIVE) && (in_color != CLR_NONE);

    for (genvar g = 0; g < NUM_COLORS; g++) begin : g_lane
        assign take_ob[g] = in_valid && (in_seg == SEG_BLACK) && (in_color == 2'(g + 1));

        ob_black_lane #(.W(W), .N(N)) u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .take   (take_ob[g]),
            .clr    (line_clr),
            .sample (in_sample),
            .black  (black_lvl[g])
        );
    end

    always_comb begin
        case (in_color)
            CLR_RED: sel_black = black_lvl[0];
            CLR_GRN: sel_black = black_lvl[1];
            CLR_BLU: sel_black = black_lvl[2];
            default: sel_black = '0;
        endcase
    end

    ob_clamp_sub #(.W(W)) u_sub (
        .minuend    (in_sample),
        .subtrahend (sel_black),
        .diff       (diff_w)
    );

    always_comb begin
        o_d     = o_q;
        o_d.vld = accept;
        if (accept) begin
            o_d.color = in_color;
            o_d.data  = diff_w;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign out_valid  = o_q.vld;
    assign out_color  = o_q.color;
    assign out_sample = o_q.data;

    // R1: a strobe always carries a real colour
    p_out_tag_r1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_color != 2'b00));

    // R2: black and dummy samples never raise the strobe
    p_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && in_seg == 2'b01 && in_color != 2'b00) |=> !out_valid);

    // R3: accepted active sample leaves one cycle later with its colour
    p_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_seg == 2'b01 && in_color != 2'b00)
            |=> (out_valid && out_color == $past(in_color)));

    // R4: correction only lowers a sample, never wraps
    p_clamp_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_seg == 2'b01 && in_color != 2'b00)
            |=> (out_sample <= $past(in_sample)));

endmodule

// File: tb/sim_ob_offset_corr.sv
module sim_ob_offset_corr;
    localparam int W = 12;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_line_start = 1'b0;
    logic [1:0]   in_color = 2'b00;
    logic [1:0]   in_seg = 2'b00;
    logic [W-1:0] in_sample = '0;
    logic         out_valid;
    logic [1:0]   out_color;
    logic [W-1:0] out_sample;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic [1:0] q_col [$];
    int         q_val [$];
    string      q_req [$];

    int m_acc [3];
    int m_cnt [3];
    int m_blk [3];

    always #4 clk = ~clk;

    ob_offset_corr #(.W(W), .N(48)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_line_start(in_line_start),
        .in_color(in_color), .in_seg(in_seg), .in_sample(in_sample),
        .out_valid(out_valid), .out_color(out_color), .out_sample(out_sample)
    );

    task automatic chk(bit ok, string req, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // monitor: pops one expected item per strobe
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (q_val.size() == 0) begin
                chk(1'b0, "R1/R2 unexpected strobe", int'(out_sample), -1);
            end else begin
                automatic logic [1:0] ec = q_col.pop_front();
                automatic int ev = q_val.pop_front();
                automatic string er = q_req.pop_front();
                chk(out_color == ec, {er, " colour"}, int'(out_color), int'(ec));
                chk(int'(out_sample) == ev, er, int'(out_sample), ev);
            end
        end
    end

    task automatic send(bit ls, logic [1:0] c, logic [1:0] s, int v, string req);
        @(negedge clk);
        in_valid = 1'b1; in_line_start = ls; in_color = c; in_seg = s; in_sample = W'(v);
        if (ls) for (int k = 0; k < 3; k++) begin m_acc[k] = 0; m_cnt[k] = 0; end
        if (c != 2'b00 && s == 2'b00 && m_cnt[c-1] < 48) begin
            m_acc[c-1] += v;
            m_cnt[c-1]++;
            if (m_cnt[c-1] == 48) m_blk[c-1] = m_acc[c-1] / 48;
        end
        if (c != 2'b00 && s == 2'b01) begin
            q_col.push_back(c);
            q_val.push_back((v > m_blk[c-1]) ? v - m_blk[c-1] : 0);
            q_req.push_back(req);
        end
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b0; in_line_start = 1'b0;
        end
    endtask

    // dropped sample: no strobe may follow it
    task automatic send_drop(logic [1:0] c, logic [1:0] s, int v, string req);
        send(1'b0, c, s, v, req);
        @(negedge clk);
        in_valid = 1'b0;
        chk(!out_valid, req, int'(out_valid), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog R3: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 3; k++) begin m_acc[k] = 0; m_cnt[k] = 0; m_blk[k] = 0; end
        repeat (3) @(negedge clk);
        chk(!out_valid, "R7 reset strobe", int'(out_valid), 0);
        rst_n = 1'b1;
        idle(2);

        // R7: black levels start at zero
        send(1'b0, 2'b01, 2'b01, 1234, "R7 red zero level");
        send(1'b0, 2'b10, 2'b01, 17,   "R7 green zero level");
        send(1'b0, 2'b11, 2'b01, 4095, "R7 blue zero level");
        idle(2);

        // R5, R4, R8: red line
        for (int i = 0; i < 48; i++)
            send(i == 0, 2'b01, 2'b00, 200 + (i * 13) % 50, "R5");
        send(1'b0, 2'b01, 2'b01, 3000, "R5 red commit next cycle");
        send(1'b0, 2'b01, 2'b01, 150,  "R4 red clamp");
        send(1'b0, 2'b01, 2'b01, m_blk[0], "R4 red equal level");
        for (int i = 0; i < 5; i++) send(1'b0, 2'b01, 2'b00, 4000, "R8");
        send(1'b0, 2'b01, 2'b01, 1000, "R8 extra black ignored");
        idle(2);

        // R1, R2: green line with untagged and dummy samples mixed in
        send(1'b1, 2'b10, 2'b00, 80, "R2");
        for (int i = 1; i < 48; i++) begin
            send(1'b0, 2'b10, 2'b00, 60 + (i * 7) % 40, "R2");
            if (i == 10) send_drop(2'b00, 2'b00, 4095, "R1 untagged black no strobe");
            if (i == 20) send_drop(2'b10, 2'b10, 4095, "R2 dummy A no strobe");
            if (i == 30) send_drop(2'b10, 2'b11, 4095, "R2 dummy B no strobe");
            if (i == 40) send_drop(2'b00, 2'b01, 4095, "R1 untagged active no strobe");
        end
        send(1'b0, 2'b10, 2'b01, 2500, "R1 green level untouched by untagged");
        send(1'b0, 2'b01, 2'b01, 2500, "R6 red level kept");
        idle(2);

        // R9: short blue run, then restart mid-run
        for (int i = 0; i < 20; i++) send(i == 0, 2'b11, 2'b00, 500, "R9");
        send(1'b1, 2'b11, 2'b01, 700, "R9 short run leaves blue at zero");
        for (int i = 0; i < 30; i++) send(1'b0, 2'b11, 2'b00, 900, "R9");
        for (int i = 0; i < 48; i++) send(i == 0, 2'b11, 2'b00, 300, "R9");
        send(1'b0, 2'b11, 2'b01, 1000, "R9 restart discards partial sum");
        idle(2);

        // R6, R5: pixel-interleaved line
        for (int i = 0; i < 48; i++) begin
            send(i == 0, 2'b01, 2'b00, 10 + i, "R6");
            send(1'b0, 2'b10, 2'b00, 1000 + 3 * i, "R6");
            send(1'b0, 2'b11, 2'b00, 2000 - 5 * i, "R6");
            if (i == 10) send(1'b0, 2'b01, 2'b01, 1500, "R5 old red level mid-run");
        end
        send(1'b0, 2'b11, 2'b01, 3500, "R5 blue commit next cycle");
        send(1'b0, 2'b01, 2'b01, 2000, "R6 red interleaved");
        send(1'b0, 2'b10, 2'b01, 2000, "R6 green interleaved");
        send(1'b0, 2'b10, 2'b01, 500,  "R4 green clamp interleaved");
        idle(4);

        chk(q_val.size() == 0, "R3 all outputs delivered", q_val.size(), 0);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule